// File: doc/BRIEF.md
# Coarse Time Stamp Latch for a Delay-Line TDC

This block gives a delay-line time-to-digital converter a measurement range longer than its delay line. A free-running binary counter runs on the system clock, the same clock that samples the delay-line register array. Each cycle, the block compares the first and last bits of the captured array. When they differ, a transition front is still inside the array, so a hit is present in that sample.

That hit indication goes through a pipeline whose depth matches the latency of the fine-time encoder. The counter value taken at the sampling edge travels alongside it. When the hit reaches the end of the pipeline, the block raises a one-cycle data-ready strobe. In the same cycle it latches the delayed coarse count together with the fine time that the encoder presents at that moment. A run of consecutive hit cycles produces only one record.

Everything downstream of the register array sits in one clock domain. Because of this, a plain binary counter is enough: no Gray coding and no counters on both clock edges are needed.

Top module: `coarse_stamp_latch`

## Requirements
- R1: The coarse counter is a plain binary counter. It clears to 0 on reset, increases by one on every clock edge and wraps from 2^CNT_W-1 to 0.
- R2: A sample carries a hit when `arr_head` and `arr_tail` differ at a clock edge. Both combinations 0/1 and 1/0 count as a hit.
- R3: For a hit sampled at clock edge e (edges counted from 0, starting at the first edge with reset low), `data_rdy` is 1 for exactly the one cycle that follows edge e+ENC_LAT.
- R4: Only the first sample of a run of consecutive hit samples produces a record. A sample that follows a hit sample is not a first sample. The sample at edge 0 after reset counts as a first sample.
- R5: With the strobe, `coarse_out` equals the counter value at the sampling edge, which is e mod 2^CNT_W.
- R6: With the strobe, `fine_out` equals the value of `fine_in` at edge e+ENC_LAT. This is the cycle in which the encoder delivers the fine time of that sample.
- R7: Between strobes, `coarse_out` and `fine_out` keep their last latched values.
- R8: A synchronous reset clears the counter, the pipeline, `data_rdy`, `coarse_out` and `fine_out`. Hits still in the pipeline when reset is applied produce no record.
- R9: When the two array ends are equal (both 0 or both 1), no record is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the array sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_head | input | 1 | First bit of the captured delay-line array |
| arr_tail | input | 1 | Last bit of the captured delay-line array |
| fine_in | input | FINE_W | Fine time from the encoder, ENC_LAT cycles after its sample |
| coarse_out | output | CNT_W | Latched coarse time of the last record |
| fine_out | output | FINE_W | Latched fine time of the last record |
| data_rdy | output | 1 | One-cycle strobe marking a new record |

## Verification
The assertions take for granted that `arr_head` and `arr_tail` are already registered, so that they hold a single stable value per clock edge. They also assume that `fine_in` belongs to the sample taken ENC_LAT edges earlier. The bench changes all inputs only on the falling edge. It treats `fine_in` as free data and predicts which of its values is captured. The stimulus includes isolated hits, long hit runs in both polarities, equal-end samples at both levels, counter wrap-around and a reset taken while hits are still in flight.

// File: rtl/coarse_stamp_pkg.sv
package coarse_stamp_pkg;

    // Default sizes shared by the block and its bench
    localparam int DEF_CNT_W   = 16;
    localparam int DEF_FINE_W  = 7;
    localparam int DEF_ENC_LAT = 2;

    // State of the hit detector: whether the previous sample held a hit
    typedef struct packed {
        logic prev_hit;
    } sense_st_t;

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        if (rst) st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count_o == $past(count_o) + {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/hit_sense.sv
module hit_sense
    import coarse_stamp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic head_i,
    input  logic tail_i,
    output logic first_o
);
    sense_st_t st_d, st_q;
    logic      hit_now;

    always_comb begin
        hit_now       = head_i ^ tail_i;
        first_o       = hit_now & ~st_q.prev_hit;
        st_d          = st_q;
        st_d.prev_hit = hit_now;
        if (rst) st_d.prev_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/align_pipe.sv
module align_pipe #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_i,
    input  logic [CNT_W-1:0] stamp_i,
    output logic             flag_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic             head_flag_o
);
    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0]            flag;
        logic [DEPTH-1:0][CNT_W-1:0] stamp;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.flag[0]  = flag_i;
        st_d.stamp[0] = stamp_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.flag[i]  = st_q.flag[i-1];
            st_d.stamp[i] = st_q.stamp[i-1];
        end
        if (rst) begin
            st_d.flag  = '0;
            st_d.stamp = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag_o      = st_q.flag[LAST];
    assign stamp_o     = st_q.stamp[LAST];
    assign head_flag_o = st_q.flag[0];

endmodule

// File: rtl/coarse_stamp_latch.sv
module coarse_stamp_latch
    import coarse_stamp_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int FINE_W  = DEF_FINE_W,
    parameter int ENC_LAT = DEF_ENC_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_head,
    input  logic              arr_tail,
    input  logic [FINE_W-1:0] fine_in,
    output logic [CNT_W-1:0]  coarse_out,
    output logic [FINE_W-1:0] fine_out,
    output logic              data_rdy
);
    typedef struct packed {
        logic [CNT_W-1:0]  coarse;
        logic [FINE_W-1:0] fine;
        logic              rdy;
    } out_st_t;

    logic [CNT_W-1:0] count;
    logic             first_hit;
    logic             launch;
    logic [CNT_W-1:0] launch_stamp;
    logic             stage0_flag;
    out_st_t          st_d, st_q;

    stamp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .count_o (count)
    );

    hit_sense u_sense (
        .clk     (clk),
        .rst     (rst),
        .head_i  (arr_head),
        .tail_i  (arr_tail),
        .first_o (first_hit)
    );

    align_pipe #(.CNT_W(CNT_W), .DEPTH(ENC_LAT)) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .flag_i      (first_hit),
        .stamp_i     (count),
        .flag_o      (launch),
        .stamp_o     (launch_stamp),
        .head_flag_o (stage0_flag)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = launch;
        if (launch) begin
            st_d.coarse = launch_stamp;
            st_d.fine   = fine_in;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign coarse_out = st_q.coarse;
    assign fine_out   = st_q.fine;
    assign data_rdy   = st_q.rdy;

    // R2
    equal_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_head == arr_tail) |=> !stage0_flag);

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        data_rdy |=> !data_rdy);

    // R5
    coarse_latch_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> data_rdy && coarse_out == $past(launch_stamp));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(coarse_out) && $stable(fine_out) && !data_rdy);

endmodule

// File: tb/tb_coarse_stamp_latch.sv
module tb_coarse_stamp_latch;
    localparam int CW  = 8;
    localparam int FW  = 7;
    localparam int LAT = 3;
    localparam int HN  = 8192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arr_head = 1'b0;
    logic          arr_tail = 1'b0;
    logic [FW-1:0] fine_in = '0;
    logic [CW-1:0] coarse_out;
    logic [FW-1:0] fine_out;
    logic          data_rdy;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit            hv_h [HN];
    logic [FW-1:0] fi_h [HN];
    logic [CW-1:0] exp_c = '0;
    logic [FW-1:0] exp_f = '0;

    coarse_stamp_latch #(.CNT_W(CW), .FINE_W(FW), .ENC_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .arr_head(arr_head), .arr_tail(arr_tail),
        .fine_in(fine_in), .coarse_out(coarse_out), .fine_out(fine_out),
        .data_rdy(data_rdy)
    );

    always #4 clk = ~clk;

    function automatic bit exp_rdy(input int nn);
        if (nn < LAT) return 1'b0;
        if (!hv_h[nn-LAT]) return 1'b0;
        if (nn - LAT >= 1 && hv_h[nn-LAT-1]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        bit er;
        int nn;
        @(posedge clk);
        hv_h[n] = arr_head ^ arr_tail;
        fi_h[n] = fine_in;
        n++;
        @(negedge clk);
        nn = n - 1;
        er = exp_rdy(nn);
        if (er) begin
            exp_c = CW'(nn - LAT);
            exp_f = fi_h[nn];
        end
        check(tag, "data_rdy", int'(data_rdy), int'(er));
        check(er ? "R5" : "R7", "coarse_out", int'(coarse_out), int'(exp_c));
        check(er ? "R6" : "R7", "fine_out", int'(fine_out), int'(exp_f));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        arr_head = 1'b0;
        arr_tail = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8", "data_rdy", int'(data_rdy), 0);
        check("R8", "coarse_out", int'(coarse_out), 0);
        check("R8", "fine_out", int'(fine_out), 0);
        rst = 1'b0;
        n = 0;
        exp_c = '0;
        exp_f = '0;
    endtask

    task automatic drive(input bit h, input bit t, input string tag);
        arr_head = h;
        arr_tail = t;
        fine_in  = FW'($urandom);
        step(tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R4: hit in the very first sample after reset
        drive(1, 0, "R4");
        repeat (6) drive(0, 0, "R3");
        // R3: isolated hits, both polarities (R2)
        drive(0, 1, "R2");
        repeat (5) drive(1, 1, "R9");
        drive(1, 0, "R3");
        drive(0, 0, "R3");
        drive(0, 1, "R3");
        repeat (6) drive(0, 0, "R7");
        // R4: long hit run yields one record
        repeat (12) drive(1, 0, "R4");
        repeat (12) drive(0, 1, "R4");
        repeat (6) drive(1, 1, "R9");
        // R1: run past a wrap of the counter
        repeat (300) drive(0, 0, "R1");
        drive(0, 1, "R1");
        repeat (6) drive(0, 0, "R1");
        // R8: reset with hits still in flight
        drive(1, 0, "R8");
        drive(0, 0, "R8");
        do_reset();
        repeat (6) drive(0, 0, "R8");
        // R2: random runs of differing and equal ends
        begin
            bit hv = 1'b0;
            for (int k = 0; k < 3000; k++) begin
                bit lvl;
                if ($urandom_range(3) == 0) hv = ~hv;
                lvl = 1'($urandom);
                drive(lvl, lvl ^ hv, "R2");
            end
        end
        repeat (6) drive(0, 0, "R7");
        finish_run();
    end

endmodule